// File: doc/BRIEF.md
# Condition Field Mask-Mode Logic Unit

This unit executes four small operations that move truth values between a condition register and the integer datapath. The condition register is held inside the unit as eight 4-bit fields. Every operation starts the same way. Each bit of a 4-bit source vector is compared against a mode pattern, and the comparison is kept only where the mask is set. The resulting four terms are then either reduced to one bit (OR or AND, chosen by the M flag) or written back as a whole field.

An operation is presented for one cycle with `op_valid` high. Its effect is visible on `cr_q`, `int_res` and `int_we` after the next rising clock edge. A field write can either overwrite the field, with masked-out bits cleared, or merge into it, with masked-out bits kept. With a zero integer source, the field-write operation acts as a way to load, set or clear field bits from the mask and mode immediates.

Top module: `cr_mask_unit`

## Requirements
- R1: After reset `cr_q` is all zero, `int_res` is zero and `int_we` is low.
- R2: Field k occupies `cr_q[4k+3:4k]`. Inside a field, bit 3 is lt, bit 2 is gt, bit 1 is eq and bit 0 is overflow. Term j is `mask[j] & (mode[j] == source bit j)`.
- R3: `op_sel` encodes 00 = field to integer, 01 = integer to field, 10 = field to single bit, 11 = field to field. Results appear one clock after the accepted cycle. A cycle with `op_valid` low changes nothing and leaves `int_we` low.
- R4: In field-to-integer mode the terms of field `src_fld` are reduced with OR when M=1 and with AND when M=0. The reduced bit goes to `int_res[0]`, the other 63 bits are zero, and `int_we` is high for that one cycle. In every other cycle `int_res` is zero.
- R5: In field-to-integer mode with Rc=0 the condition register is unchanged. With Rc=1, field 0 becomes {lt=negative, gt=positive, eq=zero, ov=0}, judged on the 64-bit result.
- R6: In integer-to-field mode only bit 0 of `int_src` is compared against every mode bit. A `ra_idx` of 0 means the source is the constant zero, whatever `int_src` holds.
- R7: In integer-to-field and field-to-field modes the terms become destination field `dst_idx[2:0]`. When M=1 the destination bits with a zero mask bit keep their value. When M=0 those bits become zero. All other fields are unchanged.
- R8: In single-bit mode `dst_idx[4:2]` picks the field and `dst_idx[1:0]` picks the bit inside it, with value 0 meaning lt, i.e. field bit 3 − `dst_idx[1:0]`. Only that bit takes the reduced value.
- R9: A field-to-field or single-bit operation whose destination is inside the source field reads the field's value from before the operation.
- R10: With `ra_idx`=0, M=0, mask 1111 and mode = ~v, the destination field is loaded with v. With M=1, mode 0000 sets the masked bits and mode 1111 clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_sel | input | 2 | Operation select |
| dst_idx | input | 5 | Destination field in [2:0], or field/bit index for single-bit mode |
| src_fld | input | 3 | Source field index |
| ra_idx | input | 5 | Integer source register index; 0 selects constant zero |
| int_src | input | 64 | Integer source value |
| mask | input | 4 | Per-bit term enable |
| mode | input | 4 | Per-bit compare pattern |
| m_flag | input | 1 | OR reduction / merge when high; AND reduction / overwrite when low |
| rc_flag | input | 1 | Record integer result analysis in field 0 |
| cr_q | output | 32 | Condition register |
| int_res | output | 64 | Integer result |
| int_we | output | 1 | Integer result write enable |

## Verification
Two things can fall in the same cycle: the read of a field and the write of that same field. The field-to-field and single-bit operations read from the source field and can write back into it. The sweep derives source and destination indices from the mask and mode values, so many of its operations land with destination equal to source. Field-to-integer with Rc=1 also overlaps a read of field 0 with a write of field 0 whenever the source is field 0. Each such case is judged against a bench model that takes the source value from before the edge.

// File: rtl/cr_mm_pkg.sv
`timescale 1ns/1ps
package cr_mm_pkg;
   typedef enum logic [1:0] {
      OP_C2I = 2'b00,
      OP_I2C = 2'b01,
      OP_BIT = 2'b10,
      OP_F2F = 2'b11
   } cr_op_e;
endpackage

// File: rtl/cr_mm_match.sv
`timescale 1ns/1ps
module cr_mm_match #(
   parameter int FW = 4
) (
   input  logic [FW-1:0] bits_i,
   input  logic [FW-1:0] mask_i,
   input  logic [FW-1:0] mode_i,
   input  logic          any_i,
   output logic [FW-1:0] terms_o,
   output logic          red_o
);
   for (genvar g = 0; g < FW; g++) begin : g_term
      assign terms_o[g] = mask_i[g] & (mode_i[g] == bits_i[g]);
   end
   assign red_o = any_i ? (|terms_o) : (&terms_o);
endmodule

// File: rtl/cr_mm_merge.sv
`timescale 1ns/1ps
module cr_mm_merge #(
   parameter int FW = 4
) (
   input  logic [FW-1:0] terms_i,
   input  logic [FW-1:0] old_i,
   input  logic [FW-1:0] mask_i,
   input  logic          keep_i,
   output logic [FW-1:0] new_o
);
   assign new_o = terms_i | (keep_i ? (old_i & ~mask_i) : '0);
endmodule

// File: rtl/cr_mm_analyse.sv
`timescale 1ns/1ps
module cr_mm_analyse #(
   parameter int XLEN = 64,
   parameter int FW   = 4
) (
   input  logic [XLEN-1:0] val_i,
   output logic [FW-1:0]   flags_o
);
   logic neg, zero;
   assign neg  = val_i[XLEN-1];
   assign zero = ~|val_i;
   always_comb begin
      flags_o       = '0;
      flags_o[FW-1] = neg;
      flags_o[FW-2] = ~neg & ~zero;
      flags_o[FW-3] = zero;
   end
endmodule

// File: rtl/cr_mask_unit.sv
`timescale 1ns/1ps
module cr_mask_unit
   import cr_mm_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter int NFLD   = 8,
   parameter int FW     = 4,
   parameter int RIDX_W = 5,
   localparam int FIDX_W = $clog2(NFLD),
   localparam int BIDX_W = $clog2(FW),
   localparam int DIDX_W = FIDX_W + BIDX_W,
   localparam int CRW    = NFLD * FW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [1:0]        op_sel,
   input  logic [DIDX_W-1:0] dst_idx,
   input  logic [FIDX_W-1:0] src_fld,
   input  logic [RIDX_W-1:0] ra_idx,
   input  logic [XLEN-1:0]   int_src,
   input  logic [FW-1:0]     mask,
   input  logic [FW-1:0]     mode,
   input  logic              m_flag,
   input  logic              rc_flag,
   output logic [CRW-1:0]    cr_q,
   output logic [XLEN-1:0]   int_res,
   output logic              int_we
);
   if (FW != 4) begin : g_fw_bad
      $error("cr_mask_unit: FW must be 4");
   end
   if (NFLD < 2 || (1 << FIDX_W) != NFLD) begin : g_nfld_bad
      $error("cr_mask_unit: NFLD must be a power of two >= 2");
   end
   if (XLEN < 2) begin : g_xlen_bad
      $error("cr_mask_unit: XLEN too small");
   end

   cr_op_e              op;
   logic [FIDX_W-1:0]   dst_fld;
   logic [BIDX_W-1:0]   bit_sel;
   logic [FW-1:0]       fld_src, dst_old, src_bits, terms, merged, rc_flags;
   logic                red, int_lsb;
   logic [XLEN-1:0]     c2i_val;
   logic [CRW-1:0]      cr_d;
   logic [XLEN-2:0]     unused_src_hi;

   assign op            = cr_op_e'(op_sel);
   assign unused_src_hi = int_src[XLEN-1:1];
   assign bit_sel       = dst_idx[BIDX_W-1:0];
   assign dst_fld       = (op == OP_BIT) ? dst_idx[DIDX_W-1:BIDX_W] : dst_idx[FIDX_W-1:0];
   assign fld_src       = cr_q[int'(src_fld)*FW +: FW];
   assign dst_old       = cr_q[int'(dst_fld)*FW +: FW];
   assign int_lsb       = (ra_idx == '0) ? 1'b0 : int_src[0];
   assign src_bits      = (op == OP_I2C) ? {FW{int_lsb}} : fld_src;
   assign c2i_val       = {{(XLEN-1){1'b0}}, red};

   cr_mm_match #(.FW(FW)) i_match (
      .bits_i (src_bits),
      .mask_i (mask),
      .mode_i (mode),
      .any_i  (m_flag),
      .terms_o(terms),
      .red_o  (red)
   );

   cr_mm_merge #(.FW(FW)) i_merge (
      .terms_i(terms),
      .old_i  (dst_old),
      .mask_i (mask),
      .keep_i (m_flag),
      .new_o  (merged)
   );

   cr_mm_analyse #(.XLEN(XLEN), .FW(FW)) i_analyse (
      .val_i  (c2i_val),
      .flags_o(rc_flags)
   );

   always_comb begin
      cr_d = cr_q;
      if (op_valid) begin
         unique case (op)
            OP_C2I: if (rc_flag) cr_d[FW-1:0] = rc_flags;
            OP_I2C, OP_F2F: cr_d[int'(dst_fld)*FW +: FW] = merged;
            OP_BIT: cr_d[int'(dst_fld)*FW + (FW-1-int'(bit_sel))] = red;
            default: cr_d = cr_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cr_q    <= '0;
         int_res <= '0;
         int_we  <= 1'b0;
      end else begin
         cr_q    <= cr_d;
         int_we  <= op_valid && (op == OP_C2I);
         int_res <= (op_valid && (op == OP_C2I)) ? c2i_val : '0;
      end
   end

   logic [CRW-1:0] mask_at_dst;
   assign mask_at_dst = {{(CRW-FW){1'b0}}, mask} << (int'(dst_idx[FIDX_W-1:0]) * FW);

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(op_valid) |-> (cr_q == $past(cr_q)) && !int_we);
   // R4
   int_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_we |-> (int_res[XLEN-1:1] == '0));
   // R4
   int_we_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_we |-> $past(op_valid && (op_sel == 2'b00)));
   // R5
   c2i_cr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(op_valid && (op_sel == 2'b00) && !rc_flag) |-> (cr_q == $past(cr_q)));
   // R5
   rc_flag_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(op_valid && (op_sel == 2'b00) && rc_flag) |->
         (!cr_q[0] && ($countones(cr_q[FW-1:1]) == 1)));
   // R8
   bit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(op_valid && (op_sel == 2'b10)) |-> ($countones(cr_q ^ $past(cr_q)) <= 1));
   // R7
   rmw_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(op_valid && op_sel[0] && m_flag) |->
         (((cr_q ^ $past(cr_q)) & ~$past(mask_at_dst)) == '0));
endmodule

// File: tb/test_cr_mask_unit.sv
`timescale 1ns/1ps
module test_cr_mask_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [1:0]  op_sel = '0;
   logic [4:0]  dst_idx = '0;
   logic [2:0]  src_fld = '0;
   logic [4:0]  ra_idx = '0;
   logic [63:0] int_src = '0;
   logic [3:0]  mask = '0, mode = '0;
   logic        m_flag = 1'b0, rc_flag = 1'b0;
   logic [31:0] cr_q;
   logic [63:0] int_res;
   logic        int_we;

   logic [31:0] mcr = '0;
   int n_cmp = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   cr_mask_unit i_cr_mask_unit (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
      .dst_idx(dst_idx), .src_fld(src_fld), .ra_idx(ra_idx), .int_src(int_src),
      .mask(mask), .mode(mode), .m_flag(m_flag), .rc_flag(rc_flag),
      .cr_q(cr_q), .int_res(int_res), .int_we(int_we)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run(input logic [1:0] op, input logic [4:0] dst, input logic [2:0] src,
                      input logic [4:0] ra, input logic [63:0] isrc, input logic [3:0] mk,
                      input logic [3:0] md, input logic m, input logic rc, input string tag);
      logic [3:0] s, t, old;
      logic       red, b;
      logic [63:0] ei;
      logic        ewe;
      int          f, p;
      ei = '0; ewe = 1'b0;
      b = (ra == 0) ? 1'b0 : isrc[0];
      s = (op == 2'b01) ? {4{b}} : mcr[4*int'(src) +: 4];
      t = mk & ~(md ^ s);
      red = m ? |t : &t;
      case (op)
         2'b00: begin
            ei = {63'd0, red}; ewe = 1'b1;
            if (rc) mcr[3:0] = red ? 4'b0100 : 4'b0010;
         end
         2'b10: begin
            f = int'(dst[4:2]); p = 4*f + 3 - int'(dst[1:0]);
            mcr[p] = red;
         end
         default: begin
            f = int'(dst[2:0]); old = mcr[4*f +: 4];
            mcr[4*f +: 4] = t | (m ? (old & ~mk) : 4'b0);
         end
      endcase
      op_valid = 1'b1; op_sel = op; dst_idx = dst; src_fld = src; ra_idx = ra;
      int_src = isrc; mask = mk; mode = md; m_flag = m; rc_flag = rc;
      @(posedge clk); @(negedge clk);
      op_valid = 1'b0;
      chk({tag, " cr"}, {32'd0, cr_q}, {32'd0, mcr});
      chk({tag, " int"}, int_res, ei);
      chk({tag, " we"}, {63'd0, int_we}, {63'd0, ewe});
   endtask

   task automatic finish_run;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] seeded;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 cr", {32'd0, cr_q}, 64'd0);
      chk("R1 int", int_res, 64'd0);
      chk("R1 we", {63'd0, int_we}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 load idiom, R2 field layout
      seeded = '0;
      for (int k = 0; k < 8; k++) begin
         logic [3:0] v;
         v = 4'((k*5+3) & 15);
         seeded[4*k +: 4] = v;
         run(2'b01, 5'(k), 3'd0, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 4'hF, ~v, 1'b0, 1'b0, "R10 load");
      end
      chk("R2 layout", {32'd0, cr_q}, {32'd0, seeded});
      // R10 set/clear idioms
      run(2'b01, 5'd3, 3'd0, 5'd0, 64'd1, 4'b0101, 4'b0000, 1'b1, 1'b0, "R10 set");
      chk("R10 set field", {60'd0, cr_q[15:12]}, {60'd0, seeded[15:12] | 4'b0101});
      run(2'b01, 5'd3, 3'd0, 5'd0, 64'd1, 4'b0100, 4'b1111, 1'b1, 1'b0, "R10 clear");
      chk("R10 clear field", {60'd0, cr_q[15:12]}, {60'd0, (seeded[15:12] | 4'b0101) & 4'b1011});
      // R6 zero index ignores int_src
      run(2'b01, 5'd5, 3'd0, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 4'hF, 4'h0, 1'b0, 1'b0, "R6 zero idx");
      chk("R6 field", {60'd0, cr_q[23:20]}, 64'hF);
      run(2'b01, 5'd5, 3'd0, 5'd7, 64'hFFFF_FFFF_FFFF_FFFE, 4'hF, 4'h0, 1'b0, 1'b0, "R6 lsb only");
      chk("R6 field lsb", {60'd0, cr_q[23:20]}, 64'hF);
      // R9 same-field field-to-field
      run(2'b01, 5'd2, 3'd0, 5'd0, 64'd0, 4'hF, 4'b0101, 1'b0, 1'b0, "R9 prep");
      run(2'b11, 5'd2, 3'd2, 5'd0, 64'd0, 4'hF, 4'b1010, 1'b0, 1'b0, "R9 self");
      chk("R9 field", {60'd0, cr_q[11:8]}, 64'hF);
      // R4 R5 R6 R7 R8 R9 exhaustive sweep over op, mask, mode, M
      for (int op = 0; op < 4; op++)
         for (int mk = 0; mk < 16; mk++)
            for (int md = 0; md < 16; md++)
               for (int m = 0; m < 2; m++) begin
                  logic [4:0] dst;
                  logic [2:0] src;
                  string      tag;
                  src = 3'((mk + md + m) % 8);
                  dst = (op == 2) ? 5'((mk*7 + md + m) % 32) : 5'((mk*3 + md) % 8);
                  case (op)
                     0: tag = "R4 R5 c2i";
                     1: tag = "R6 R7 i2c";
                     2: tag = "R8 R2 R9 bit";
                     default: tag = "R7 R9 f2f";
                  endcase
                  run(2'(op), dst, src, 5'(md[0] ? 3 : (m ? 9 : 0)),
                      {32'hA5A5_0000, 31'd0, 1'(mk[0] ^ md[1])}, 4'(mk), 4'(md),
                      1'(m), 1'(mk[1] ^ md[0]), tag);
               end
      // R3 idle cycles change nothing
      op_sel = 2'b01; mask = 4'hF; mode = 4'h0; m_flag = 1'b0; dst_idx = 5'd1;
      repeat (2) @(negedge clk);
      chk("R3 idle cr", {32'd0, cr_q}, {32'd0, mcr});
      chk("R3 idle we", {63'd0, int_we}, 64'd0);
      chk("R4 idle int", int_res, 64'd0);
      finish_run();
   end
endmodule